// File: doc/BRIEF.md
# Nonvolatile Memory Access Controller

This block is the access controller for a small on-chip nonvolatile memory. Software drives it through one 8-bit control and status register. The register selects one of three spaces: program memory, data memory or configuration words. It also gates programming with a write-enable bit and launches reads, word writes or program-memory row erases. A self-timed sequencer counts out each write or erase. When the count ends, the sequencer commits the operation to the array and clears the start bit. If a warm reset cuts a write or erase short, the sequencer records an error flag that persists, so software can still see which space was being programmed.

The memory is an internal array split into three spaces. Power-on reset brings every space up blank (all ones). The address and the data to program come from plain inputs that stand in for the pointer and data registers. A completed read comes back on `rd_data` with a one-clock `rd_valid` strobe. This result stream has no ready signal, so the consumer cannot apply back-pressure: it must take the word in the cycle the strobe is high. A separate fetch port gives registered read access to program memory, because the control register cannot read that space.

Top module: `nvm_ctrl`

## Requirements
- R1: Register bit map: bit 7 selects program memory, bit 6 selects configuration space, bit 5 always reads 0, bit 4 is row-erase enable, bit 3 is the error flag, bit 2 is write enable, bit 1 is write start and bit 0 is read start. Bits 7, 6, 4, 3 and 2 read back as last written.
- R2: A register write with bit 1 and bit 2 both set while idle starts a write. `busy` is high for exactly WR_CYCLES clocks. The word on `nvm_wdata` is then stored at `nvm_addr`, and bit 1 clears at the same edge that `busy` falls. Writing 0 to bit 1 has no effect.
- R3: When the written value has bit 2 at 0, a write start is ignored. `busy` stays low, bit 1 stays 0 and the memory is unchanged.
- R4: Writing bit 0 as 1 starts a read. Bit 0 reads 1 for one clock and then clears. At that point `rd_valid` pulses for one clock with the addressed word on `rd_data`, taken from configuration space if bit 6 is 1 and from data memory otherwise.
- R5: A read start whose written value has bit 7 at 1 is ignored. Bit 0 stays 0 and no `rd_valid` appears.
- R6: With bit 4 set, a write start erases the whole program-memory row that holds `nvm_addr`, ignoring its low ROW_BITS bits, so every word of that row reads all ones. The cycle lasts ERASE_CYCLES clocks, and completion clears bit 4. Other rows keep their contents.
- R7: A write targets configuration space when bit 6 is 1, program memory when only bit 7 is 1, and data memory otherwise. The three spaces are independent.
- R8: While `busy`, a further write start is ignored. The running cycle keeps its original length, target and data, and the select bits from that register write are still taken.
- R9: Warm reset during a cycle aborts it without changing memory, sets bit 3, and clears bits 1 and 2 while keeping bits 7 and 6. A warm reset while idle leaves bit 3 as it was.
- R10: Power-on reset clears every register bit, the error flag included, and returns all memory to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| wrst_n | input | 1 | Warm reset, synchronous, active low |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write value |
| reg_rdata | output | 8 | Control register read value |
| nvm_addr | input | ADDR_W | Word address for read, write or erase |
| nvm_wdata | input | DATA_W | Word to program |
| rd_valid | output | 1 | One-clock strobe for a completed read |
| rd_data | output | DATA_W | Read result, valid with `rd_valid` |
| fetch_addr | input | ADDR_W | Program memory fetch address |
| fetch_data | output | DATA_W | Registered program memory word at `fetch_addr` |
| busy | output | 1 | High for the whole self-timed cycle |

## Verification
Writes go to all three spaces at overlapping low addresses. Read-back then shows that the space select routes each word to its own array rather than to a shared one. Row erase is issued with an address whose low bits are all ones, and a word in the same row is checked alongside a word in the neighbouring row, which shows both the masking and the row boundary. Each rejected start is followed by a read of the memory it could have touched, and these reads separate a start that was ignored from one that ran late: missing write enable, a read with program memory selected, a second start while busy, and a cycle cut off by warm reset. The busy length is counted clock by clock for both writes and erases.

// File: rtl/nvm_ctrl_pkg.sv
package nvm_ctrl_pkg;

  // Control register bit positions (fixed by the software map)
  localparam int B_PROG  = 7;
  localparam int B_CFG   = 6;
  localparam int B_SPARE = 5;
  localparam int B_ERASE = 4;
  localparam int B_ERR   = 3;
  localparam int B_WREN  = 2;
  localparam int B_WGO   = 1;
  localparam int B_RGO   = 0;

  typedef enum logic [1:0] {
    SPACE_DATA = 2'd0,
    SPACE_PROG = 2'd1,
    SPACE_CFG  = 2'd2
  } nvm_space_e;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_ERASE = 2'd2
  } nvm_op_e;

  typedef struct packed {
    logic prog_sel;
    logic cfg_sel;
    logic erase_en;
    logic err;
    logic wr_en;
    logic wr_go;
    logic rd_go;
  } nvm_ctl_t;

  function automatic nvm_space_e pick_space(input logic prog_sel, input logic cfg_sel);
    if (cfg_sel)       return SPACE_CFG;
    else if (prog_sel) return SPACE_PROG;
    else               return SPACE_DATA;
  endfunction

endpackage

// File: rtl/nvm_ctrl_regs.sv
module nvm_ctrl_regs
  import nvm_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  logic       wrst_n,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  input  logic       busy,
  input  logic       cyc_done,
  input  logic       cyc_erase,
  output nvm_ctl_t   ctl,
  output logic       start_wr,
  output logic       start_rd,
  output logic [7:0] reg_rdata
);

  logic spare_unused;
  assign spare_unused = reg_wdata[B_SPARE];

  // Start requests: set-only bits, qualified by enable, space and idle state
  assign start_wr = reg_we && wrst_n && reg_wdata[B_WGO] && reg_wdata[B_WREN] && !busy;
  assign start_rd = reg_we && wrst_n && reg_wdata[B_RGO] && !reg_wdata[B_PROG];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ctl <= '0;
    end else if (!wrst_n) begin
      ctl.err   <= ctl.err | busy;
      ctl.wr_go <= 1'b0;
      ctl.wr_en <= 1'b0;
      ctl.rd_go <= 1'b0;
    end else begin
      if (reg_we) begin
        ctl.prog_sel <= reg_wdata[B_PROG];
        ctl.cfg_sel  <= reg_wdata[B_CFG];
        ctl.erase_en <= reg_wdata[B_ERASE];
        ctl.err      <= reg_wdata[B_ERR];
        ctl.wr_en    <= reg_wdata[B_WREN];
      end
      if (cyc_done) begin
        ctl.wr_go <= 1'b0;
        if (cyc_erase) ctl.erase_en <= 1'b0;
      end
      if (start_wr) ctl.wr_go <= 1'b1;
      ctl.rd_go <= start_rd;
    end
  end

  always_comb begin
    reg_rdata          = '0;
    reg_rdata[B_PROG]  = ctl.prog_sel;
    reg_rdata[B_CFG]   = ctl.cfg_sel;
    reg_rdata[B_ERASE] = ctl.erase_en;
    reg_rdata[B_ERR]   = ctl.err;
    reg_rdata[B_WREN]  = ctl.wr_en;
    reg_rdata[B_WGO]   = ctl.wr_go;
    reg_rdata[B_RGO]   = ctl.rd_go;
  end

endmodule

// File: rtl/nvm_ctrl_seq.sv
module nvm_ctrl_seq
  import nvm_ctrl_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 8,
  parameter int ROW_BITS     = 6,
  parameter int WR_CYCLES    = 16,
  parameter int ERASE_CYCLES = 32
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              wrst_n,
  input  logic              start,
  input  logic              erase_req,
  input  nvm_space_e        space,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              busy,
  output logic              done,
  output logic              done_erase,
  output nvm_space_e        c_space,
  output logic [ADDR_W-1:0] c_addr,
  output logic [DATA_W-1:0] c_data
);

  localparam int LONGEST = (WR_CYCLES > ERASE_CYCLES) ? WR_CYCLES : ERASE_CYCLES;
  localparam int CNT_W   = (LONGEST > 2) ? $clog2(LONGEST) : 1;
  localparam logic [ADDR_W-1:0] ROW_MASK = ~ADDR_W'((1 << ROW_BITS) - 1);

  nvm_op_e           op;
  logic [CNT_W-1:0]  cnt;

  assign busy       = (op != OP_IDLE);
  assign done       = busy && (cnt == '0) && wrst_n;
  assign done_erase = done && (op == OP_ERASE);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      op      <= OP_IDLE;
      cnt     <= '0;
      c_space <= SPACE_DATA;
      c_addr  <= '0;
      c_data  <= '0;
    end else if (!wrst_n) begin
      op  <= OP_IDLE;
      cnt <= '0;
    end else if (start) begin
      if (erase_req) begin
        op      <= OP_ERASE;
        cnt     <= CNT_W'(ERASE_CYCLES - 1);
        c_space <= SPACE_PROG;
        c_addr  <= addr & ROW_MASK;
      end else begin
        op      <= OP_WRITE;
        cnt     <= CNT_W'(WR_CYCLES - 1);
        c_space <= space;
        c_addr  <= addr;
      end
      c_data <= wdata;
    end else if (done) begin
      op <= OP_IDLE;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/nvm_ctrl_mem.sv
module nvm_ctrl_mem
  import nvm_ctrl_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int PROG_DEPTH = 256,
  parameter int DATA_DEPTH = 64,
  parameter int CFG_DEPTH  = 8,
  parameter int ROW_BITS   = 6
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              c_en,
  input  logic              c_erase,
  input  nvm_space_e        c_space,
  input  logic [ADDR_W-1:0] c_addr,
  input  logic [DATA_W-1:0] c_data,
  input  logic              rd_en,
  input  nvm_space_e        rd_space,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] fetch_data
);

  localparam int NSPACE    = 3;
  localparam int ROW_WORDS = 1 << ROW_BITS;

  logic [DATA_W-1:0] rd_word [NSPACE];
  logic [DATA_W-1:0] fetch_word;

  for (genvar s = 0; s < NSPACE; s++) begin : g_space
    localparam int DEPTH = (s == 0) ? DATA_DEPTH : ((s == 1) ? PROG_DEPTH : CFG_DEPTH);
    localparam int AW    = (DEPTH > 2) ? $clog2(DEPTH) : 1;
    localparam logic [1:0] SID = 2'(s);

    logic [DATA_W-1:0] cells [DEPTH];
    logic [AW-1:0]     widx;
    logic              hit;

    assign widx = c_addr[AW-1:0];
    assign hit  = c_en && (c_space == nvm_space_e'(SID));

    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
        for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
      end else if (hit) begin
        if (c_erase) begin
          for (int i = 0; i < DEPTH; i++) begin
            if ((i / ROW_WORDS) == (int'(widx) / ROW_WORDS)) cells[i] <= '1;
          end
        end else begin
          cells[widx] <= c_data;
        end
      end
    end

    assign rd_word[s] = cells[rd_addr[AW-1:0]];

    if (s == 1) begin : g_fetch
      assign fetch_word = cells[fetch_addr[AW-1:0]];
    end
  end

  logic [DATA_W-1:0] rd_pick;
  always_comb begin
    case (rd_space)
      SPACE_PROG: rd_pick = rd_word[1];
      SPACE_CFG:  rd_pick = rd_word[2];
      default:    rd_pick = rd_word[0];
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      fetch_data <= '1;
    end else begin
      rd_valid   <= rd_en;
      fetch_data <= fetch_word;
      if (rd_en) rd_data <= rd_pick;
    end
  end

endmodule

// File: rtl/nvm_ctrl.sv
module nvm_ctrl
  import nvm_ctrl_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 8,
  parameter int PROG_DEPTH   = 256,
  parameter int DATA_DEPTH   = 64,
  parameter int CFG_DEPTH    = 8,
  parameter int ROW_BITS     = 6,
  parameter int WR_CYCLES    = 16,
  parameter int ERASE_CYCLES = 32
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              wrst_n,
  input  logic              reg_we,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic [ADDR_W-1:0] nvm_addr,
  input  logic [DATA_W-1:0] nvm_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic [DATA_W-1:0] fetch_data,
  output logic              busy
);

  nvm_ctl_t          ctl;
  logic              start_wr, start_rd;
  logic              cyc_done, cyc_erase;
  nvm_space_e        sel_space, c_space;
  logic [ADDR_W-1:0] c_addr;
  logic [DATA_W-1:0] c_data;

  assign sel_space = pick_space(ctl.prog_sel, ctl.cfg_sel);

  nvm_space_e next_space;
  assign next_space = pick_space(reg_wdata[B_PROG], reg_wdata[B_CFG]);

  nvm_ctrl_regs u_regs (
    .clk       (clk),
    .por_n     (por_n),
    .wrst_n    (wrst_n),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .busy      (busy),
    .cyc_done  (cyc_done),
    .cyc_erase (cyc_erase),
    .ctl       (ctl),
    .start_wr  (start_wr),
    .start_rd  (start_rd),
    .reg_rdata (reg_rdata)
  );

  nvm_ctrl_seq #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .ROW_BITS     (ROW_BITS),
    .WR_CYCLES    (WR_CYCLES),
    .ERASE_CYCLES (ERASE_CYCLES)
  ) u_seq (
    .clk        (clk),
    .por_n      (por_n),
    .wrst_n     (wrst_n),
    .start      (start_wr),
    .erase_req  (reg_wdata[B_ERASE]),
    .space      (next_space),
    .addr       (nvm_addr),
    .wdata      (nvm_wdata),
    .busy       (busy),
    .done       (cyc_done),
    .done_erase (cyc_erase),
    .c_space    (c_space),
    .c_addr     (c_addr),
    .c_data     (c_data)
  );

  nvm_ctrl_mem #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .PROG_DEPTH (PROG_DEPTH),
    .DATA_DEPTH (DATA_DEPTH),
    .CFG_DEPTH  (CFG_DEPTH),
    .ROW_BITS   (ROW_BITS)
  ) u_mem (
    .clk        (clk),
    .por_n      (por_n),
    .c_en       (cyc_done),
    .c_erase    (cyc_erase),
    .c_space    (c_space),
    .c_addr     (c_addr),
    .c_data     (c_data),
    .rd_en      (ctl.rd_go),
    .rd_space   (sel_space),
    .rd_addr    (nvm_addr),
    .fetch_addr (fetch_addr),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .fetch_data (fetch_data)
  );

endmodule

// File: rtl/nvm_ctrl_chk.sv
module nvm_ctrl_chk (
  input logic       clk,
  input logic       por_n,
  input logic       wrst_n,
  input logic [7:0] reg_rdata,
  input logic       busy,
  input logic       rd_valid
);

  // R1
  spare_bit_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
    reg_rdata[5] == 1'b0);

  // R2
  wr_clear_idle_chk: assert property (@(posedge clk) disable iff (!por_n)
    $fell(reg_rdata[1]) |-> !busy);

  // R3
  start_needs_wren_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(busy) |-> reg_rdata[2]);

  // R4
  rd_after_go_chk: assert property (@(posedge clk) disable iff (!por_n)
    rd_valid |-> $past(reg_rdata[0]));

  // R4
  rd_self_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
    reg_rdata[0] |=> !reg_rdata[0]);

  // R5
  rd_not_prog_chk: assert property (@(posedge clk) disable iff (!por_n)
    reg_rdata[0] |-> !reg_rdata[7]);

  // R9
  abort_flag_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!wrst_n && busy) |=> (reg_rdata[3] && !busy && !reg_rdata[1] && !reg_rdata[2]));

  // R9
  warm_keeps_sel_chk: assert property (@(posedge clk) disable iff (!por_n)
    !wrst_n |=> $stable(reg_rdata[7:6]));

endmodule

bind nvm_ctrl nvm_ctrl_chk u_chk (
  .clk       (clk),
  .por_n     (por_n),
  .wrst_n    (wrst_n),
  .reg_rdata (reg_rdata),
  .busy      (busy),
  .rd_valid  (rd_valid)
);

// File: tb/nvm_ctrl_tb_top.sv
module nvm_ctrl_tb_top;

  localparam int WRC = 16;
  localparam int ERC = 32;

  logic       clk = 1'b0;
  logic       por_n = 1'b0, wrst_n = 1'b1, reg_we = 1'b0;
  logic [7:0] reg_wdata = '0, nvm_addr = '0, nvm_wdata = '0, fetch_addr = '0;
  logic [7:0] reg_rdata, rd_data, fetch_data;
  logic       rd_valid, busy;

  always #5 clk = ~clk;

  nvm_ctrl dut_i (
    .clk(clk), .por_n(por_n), .wrst_n(wrst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .nvm_addr(nvm_addr), .nvm_wdata(nvm_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .fetch_addr(fetch_addr), .fetch_data(fetch_data), .busy(busy)
  );

  int n_cmp = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  logic [7:0] mon_exp;
  bit done_flag = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: every read result is popped and compared
  always @(negedge clk) begin
    if (por_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R5: actual read result %0h expected none", rd_data);
      end else begin
        mon_exp = exp_q.pop_front();
        chk("R4 read data", {24'd0, rd_data}, {24'd0, mon_exp});
      end
    end
  end

  task automatic reg_write(input logic [7:0] v);
    reg_we = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic nvm_store(input logic [7:0] sel, input logic [7:0] a, input logic [7:0] d);
    int n;
    nvm_addr = a; nvm_wdata = d;
    reg_write(sel | 8'h04);
    reg_write(sel | 8'h06);
    wait_idle(n);
    chk("R2 write busy length", n, WRC);
    chk("R2 start bit cleared", {24'd0, reg_rdata}, {24'd0, sel | 8'h04});
  endtask

  task automatic nvm_load(input logic [7:0] sel, input logic [7:0] a, input logic [7:0] e);
    nvm_addr = a;
    exp_q.push_back(e);
    reg_write(sel | 8'h01);
    chk("R4 read bit set", reg_rdata[0], 1);
    @(negedge clk);
    chk("R4 read bit self clears", reg_rdata[0], 0);
  endtask

  task automatic fetch(input logic [7:0] a, input logic [7:0] e, input string req);
    fetch_addr = a;
    @(negedge clk);
    chk(req, fetch_data, e);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    // R10 / R1 reset state
    chk("R10 reset register", reg_rdata, 8'h00);
    chk("R10 reset busy", busy, 0);

    // R1 bit map: bit 5 reads 0, others read back
    reg_write(8'hFC);
    chk("R1 readback", reg_rdata, 8'hDC);
    reg_write(8'h00);
    chk("R1 clear", reg_rdata, 8'h00);

    // R2 data write and read back; writing 0 to start bit has no effect
    nvm_addr = 8'd5; nvm_wdata = 8'hA5;
    reg_write(8'h04);
    reg_write(8'h06);
    reg_write(8'h04);
    chk("R2 start bit not clearable", reg_rdata[1], 1);
    wait_idle(n);
    chk("R2 busy length", 1 + n, WRC);
    nvm_load(8'h00, 8'd5, 8'hA5);

    // R3 write enable low: start ignored
    nvm_addr = 8'd6; nvm_wdata = 8'h11;
    reg_write(8'h02);
    chk("R3 no busy", busy, 0);
    chk("R3 start bit", reg_rdata[1], 0);
    nvm_load(8'h00, 8'd6, 8'hFF);

    // R5 read with program select: ignored
    reg_write(8'h81);
    chk("R5 read bit blocked", reg_rdata[0], 0);
    @(negedge clk);

    // R7 space routing
    nvm_store(8'h40, 8'd2, 8'h3C);
    nvm_store(8'h80, 8'd70, 8'h77);
    nvm_store(8'h80, 8'd10, 8'h10);
    nvm_load(8'h40, 8'd2, 8'h3C);
    nvm_load(8'h00, 8'd2, 8'hFF);
    fetch(8'd70, 8'h77, "R7 program word");
    fetch(8'd10, 8'h10, "R7 program word row0");
    fetch(8'd2, 8'hFF, "R7 program untouched");

    // R6 row erase with low address bits set
    nvm_addr = 8'h7F;
    reg_write(8'h94);
    reg_write(8'h96);
    wait_idle(n);
    chk("R6 erase busy length", n, ERC);
    chk("R6 erase enable cleared", reg_rdata, 8'h84);
    fetch(8'd70, 8'hFF, "R6 erased word");
    fetch(8'd64, 8'hFF, "R6 erased row start");
    fetch(8'd10, 8'h10, "R6 other row kept");

    // R8 second start while busy ignored, select still taken
    nvm_addr = 8'd3; nvm_wdata = 8'h42;
    reg_write(8'h04);
    reg_write(8'h06);
    repeat (2) @(negedge clk);
    nvm_wdata = 8'h99;
    reg_write(8'h46);
    chk("R8 select taken while busy", reg_rdata[6], 1);
    wait_idle(n);
    chk("R8 busy length unchanged", 3 + n, WRC);
    nvm_load(8'h40, 8'd3, 8'hFF);
    nvm_load(8'h00, 8'd3, 8'h42);

    // R9 warm reset during program write
    nvm_addr = 8'd20; nvm_wdata = 8'h5A;
    reg_write(8'h84);
    reg_write(8'h86);
    repeat (4) @(negedge clk);
    wrst_n = 1'b0;
    @(negedge clk);
    wrst_n = 1'b1;
    chk("R9 busy aborted", busy, 0);
    chk("R9 register after abort", reg_rdata, 8'h88);
    fetch(8'd20, 8'hFF, "R9 memory unchanged");
    wrst_n = 1'b0;
    @(negedge clk);
    wrst_n = 1'b1;
    chk("R9 idle warm reset keeps flag", reg_rdata, 8'h88);

    // R10 power-on reset clears all
    por_n = 1'b0;
    @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    chk("R10 register cleared", reg_rdata, 8'h00);
    nvm_load(8'h00, 8'd5, 8'hFF);
    fetch(8'd10, 8'hFF, "R10 program blank");
    @(negedge clk);
    chk("R4 scoreboard drained", exp_q.size(), 0);

    done_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule